// File: doc/BRIEF.md
# Serial-Programmed Clock Output Gate

This block is a receive-only target on a two-wire serial bus. It drives a bank of buffered copies of a reference clock, and it accepts writes that switch individual copies on or off. The bus lines are sampled in the system clock domain. The block answers on the data line only by pulling it low through an output enable.

A write transaction has the following parts:

- A start condition.
- The address byte 0xD2. This is the 7-bit target address 0x69 with the direction bit (LSB) at 0.
- Two preamble bytes. The block acknowledges them and throws their contents away.
- Any number of data bytes, ended by a stop or by a new start.

There is no register pointer. The first data byte always lands in control register one and the second in control register two. To change register two, the host must therefore also resend register one.

The first eight outputs always run. Outputs 8 to 17 follow their enable bits, and the gating is free of glitches.

Top module: `twowire_clken_slave`

## Requirements
- R1: A falling SDA while SCL is high starts a transfer. A rising SDA while SCL is high ends it. After a stop, bytes clocked on the bus are not acknowledged and change no output until the next start.
- R2: The first byte after a start is taken MSB first. If it equals 0xD2, the block holds SDA low for the whole ninth SCL pulse.
- R3: For any other first byte, including the read request 0xD3, the ninth pulse is not acknowledged. The rest of that transfer is not acknowledged either and leaves every output enable unchanged.
- R4: After an acknowledged address, the next two bytes are acknowledged. Their values have no influence on any output.
- R5: The first data byte loads register one, and its bit b (b = 0..7) enables output 8+b. The second data byte loads register two: bit 7 enables output 17 and bit 6 enables output 16. Bits 5..0 of register two have no effect. In both registers, 1 means running and 0 means stopped.
- R6: A third and any later data byte in the same transfer is acknowledged and changes nothing.
- R7: A start or stop that arrives before all eight bits of a byte have been clocked in discards that byte. No enable changes. A repeated start begins a fresh address phase.
- R8: After reset, every output enable is 1. Outputs 0..7 copy the reference clock at all times.
- R9: Every output is low while the reference clock is low. A disabled output stays low, and an enable takes effect only on a falling reference edge.
- R10: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for bus sampling and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be buffered |
| clk_out | output | 18 | Gated copies of the reference clock |

## Verification
Two events can coincide:

- A register write that the bus completes.
- A falling edge of the reference clock, which moves the enables onto the outputs.

The bench runs the reference clock at a period unrelated to the system clock. Commits therefore fall at every phase of it, including right on the sampling edge.

After each transfer the bench compares the outputs, while the reference is high, against a model of the two registers. While the reference is low it requires every output to be 0. In parallel, it watches every change of the SDA pull against the level of SCL.

// File: rtl/twowire_clken_slave.sv
`timescale 1ns/1ps
module twowire_clken_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         NUM_REGS   = 2,
  parameter int         FIXED_OUTS = 8,
  parameter int         NUM_OUTS   = 18,
  parameter int         SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_oe,
  input  logic                ref_clk,
  output logic [NUM_OUTS-1:0] clk_out
);
  localparam int CTRL_BITS = NUM_OUTS - FIXED_OUTS;
  localparam int LOW_BITS  = 8 * (NUM_REGS - 1);
  localparam int PAD       = 8 * NUM_REGS - CTRL_BITS;
  localparam int IW        = $clog2(NUM_REGS + 1);
  localparam logic [IW-1:0] END_IDX = IW'(NUM_REGS);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_SKIP} phase_t;

  function automatic int bit_home(input int c);
    return (c < LOW_BITS) ? c : c + PAD;
  endfunction

  logic [SYNC_DEPTH:0] scl_pipe, sda_pipe;
  logic scl_now, scl_old, sda_now, sda_old;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_DEPTH-1:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_DEPTH-1:0], sda_in};
    end

  assign scl_now   = scl_pipe[SYNC_DEPTH-1];
  assign scl_old   = scl_pipe[SYNC_DEPTH];
  assign sda_now   = sda_pipe[SYNC_DEPTH-1];
  assign sda_old   = sda_pipe[SYNC_DEPTH];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign bus_start = scl_now & scl_old & sda_old & ~sda_now;
  assign bus_stop  = scl_now & scl_old & ~sda_old & sda_now;

  phase_t                phase;
  logic [3:0]            bitcnt;
  logic                  in_ack;
  logic [7:0]            shreg;
  logic [IW-1:0]         widx;
  logic [CTRL_BITS-1:0]  ctl_q;
  logic                  byte_done;

  assign byte_done = scl_fall & ~in_ack & (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
      shreg  <= '0;
      widx   <= '0;
      ctl_q  <= '1;
    end else if (bus_start || bus_stop) begin
      phase  <= bus_start ? ST_ADDR : ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
      widx   <= '0;
    end else if (phase != ST_IDLE && phase != ST_SKIP) begin
      if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_now};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end
      if (byte_done) begin
        in_ack <= 1'b1;
        sda_oe <= 1'b1;
        unique case (phase)
          ST_ADDR: begin
            if (shreg != {DEV_ADDR, 1'b0}) begin
              phase  <= ST_SKIP;
              in_ack <= 1'b0;
              sda_oe <= 1'b0;
            end else begin
              phase <= ST_CMD;
            end
          end
          ST_CMD: phase <= ST_CNT;
          ST_CNT: phase <= ST_DATA;
          default: begin
            if (widx != END_IDX) begin
              for (int c = 0; c < CTRL_BITS; c++)
                if (widx == IW'(bit_home(c) / 8))
                  ctl_q[c] <= shreg[3'(bit_home(c) % 8)];
              widx <= widx + 1'b1;
            end
          end
        endcase
      end
    end

  genvar g;
  generate
    for (g = 0; g < NUM_OUTS; g++) begin : g_out
      if (g < FIXED_OUTS) begin : g_free
        assign clk_out[g] = ref_clk;
      end else begin : g_gate
        logic en_s1, en_q;
        always_ff @(negedge ref_clk or negedge rst_n)
          if (!rst_n) begin
            en_s1 <= 1'b1;
            en_q  <= 1'b1;
          end else begin
            en_s1 <= ctl_q[g-FIXED_OUTS];
            en_q  <= en_s1;
          end
        assign clk_out[g] = ref_clk & en_q;
      end
    end
  endgenerate
endmodule

module twowire_clken_slave_chk #(
  parameter int FIXED_OUTS = 8,
  parameter int NUM_OUTS   = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_in,
  input logic                sda_oe,
  input logic                ref_clk,
  input logic [NUM_OUTS-1:0] clk_out,
  input logic [3:0]          bitcnt
);
  assert_pull_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);
  assert_pull_off_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_in);
  assert_ack_after_eight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> bitcnt == 4'd8);
  assert_bit_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
  assert_low_with_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clk |-> clk_out == '0);
  assert_fixed_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clk |-> &clk_out[FIXED_OUTS-1:0]);
endmodule

bind twowire_clken_slave twowire_clken_slave_chk #(
  .FIXED_OUTS(FIXED_OUTS), .NUM_OUTS(NUM_OUTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .ref_clk(ref_clk), .clk_out(clk_out), .bitcnt(bitcnt)
);

// File: tb/twowire_clken_slave_tb.sv
`timescale 1ns/1ps
module twowire_clken_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_bus;
  logic [17:0] clk_out;
  int checks = 0, fails = 0, oe_bad = 0;
  logic [7:0] m_r1 = 8'hFF, m_r2 = 8'hFF;
  logic [7:0] pay [10];

  always #2.5 clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;
  assign sda_bus = ~(m_low | sda_oe);

  twowire_clken_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .ref_clk(ref_clk), .clk_out(clk_out)
  );

  always @(sda_oe) if (rst_n && m_scl) oe_bad++;

  function automatic logic [17:0] exp_out(input logic [7:0] r1, input logic [7:0] r2);
    return {r2[7:6], r1, 8'hFF};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_start();
    if (!m_scl) begin
      waitc(4); m_low = 1'b0; waitc(Q); m_scl = 1'b1; waitc(Q);
    end else begin
      m_low = 1'b0; waitc(Q);
    end
    m_low = 1'b1; waitc(Q); m_scl = 1'b0; waitc(4);
  endtask

  task automatic do_stop();
    waitc(4); m_low = 1'b1; waitc(Q); m_scl = 1'b1; waitc(Q); m_low = 1'b0; waitc(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      waitc(4); m_low = ~b[i]; waitc(Q);
      m_scl = 1'b1; waitc(2*Q); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    waitc(4); m_low = 1'b0; waitc(Q);
    m_scl = 1'b1; waitc(Q); ack = ~sda_bus; waitc(Q); m_scl = 1'b0;
  endtask

  // abort: 0 = clean stop, 1 = stop after partial byte, 2 = repeated start after partial byte
  task automatic run_txn(input logic [7:0] addr, input int n, input int abort, output bit acks_ok);
    logic a;
    bit hit;
    hit = (addr == 8'hD2);
    acks_ok = 1'b1;
    do_start();
    send_byte(addr, a);
    if (a !== hit) acks_ok = 1'b0;
    for (int k = 0; k < n; k++) begin
      send_byte(pay[k], a);
      if (a !== hit) acks_ok = 1'b0;
      if (hit && k == 2) m_r1 = pay[k];
      if (hit && k == 3) m_r2 = pay[k];
    end
    if (abort != 0) send_bits(8'h3C ^ addr, 1 + (n % 7));
    if (abort == 2) do_start();
    do_stop();
  endtask

  task automatic check_outs(input string tag);
    logic [17:0] e;
    repeat (6) @(posedge ref_clk);
    #1;
    e = exp_out(m_r1, m_r2);
    check(clk_out === e, tag, 32'(clk_out), 32'(e));
    @(negedge ref_clk);
    #1;
    check(clk_out === '0, "R9", 32'(clk_out), 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1 watchdog", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    logic a;
    int mode, nb;
    logic [7:0] adr;
    void'($urandom(32'h5eed1234));
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    check_outs("R8 reset enables");

    pay[0] = 8'hFF; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h00;
    run_txn(8'hD2, 4, 0, ok);
    check(ok, "R2 R4 acks", 32'(ok), 32'h1);
    check_outs("R4 R5 all gated off");

    pay[0] = 8'h5A; pay[1] = 8'h01; pay[2] = 8'hA5; pay[3] = 8'h3F;
    run_txn(8'hD2, 4, 0, ok);
    check(ok, "R2 acks", 32'(ok), 32'h1);
    check_outs("R5 reserved bits");

    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h0F; pay[3] = 8'hC0;
    pay[4] = 8'h00; pay[5] = 8'hFF; pay[6] = 8'h12; pay[7] = 8'h34;
    run_txn(8'hD2, 8, 0, ok);
    check(ok, "R6 extra bytes acked", 32'(ok), 32'h1);
    check_outs("R6 extra bytes discarded");

    pay[2] = 8'h00; pay[3] = 8'h00;
    run_txn(8'hD3, 4, 0, ok);
    check(ok, "R3 read not acked", 32'(ok), 32'h1);
    check_outs("R3 read no change");
    run_txn(8'hA4, 4, 0, ok);
    check(ok, "R3 foreign address not acked", 32'(ok), 32'h1);
    check_outs("R3 foreign no change");

    pay[0] = 8'h00; pay[1] = 8'h00; pay[2] = 8'h55;
    run_txn(8'hD2, 3, 1, ok);
    check(ok, "R7 acks", 32'(ok), 32'h1);
    check_outs("R7 stop mid byte");
    run_txn(8'hD2, 2, 2, ok);
    check(ok, "R7 acks", 32'(ok), 32'h1);
    check_outs("R7 restart mid byte");

    m_scl = 1'b0;
    waitc(Q);
    send_byte(8'hD2, a);
    check(a === 1'b0, "R1 no ack without start", 32'(a), 32'h0);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h00, a);
      if (a !== 1'b0) check(1'b0, "R1 data ack without start", 32'(a), 32'h0);
    end
    do_stop();
    check_outs("R1 idle bytes ignored");

    for (int t = 0; t < 22; t++) begin
      mode = $urandom_range(9);
      adr = (mode < 7) ? 8'hD2 : (mode < 8 ? 8'hD3 : 8'($urandom));
      nb = $urandom_range(6);
      for (int k = 0; k < 10; k++) pay[k] = 8'($urandom);
      run_txn(adr, nb, $urandom_range(2), ok);
      check(ok, "R2 R3 random acks", 32'(ok), 32'h1);
      check_outs("R5 random outputs");
    end

    check(oe_bad == 0, "R10 pull changed with SCL high", 32'(oe_bad), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule